// File: doc/BRIEF.md
# Interrupt presenter

This block sits beside one processor and decides which interrupt, if any, that processor is currently offered. It keeps a 32-bit presentation register whose top byte is the processor's current priority and whose low 24 bits name the pending source. It also keeps a pending priority and an inter-processor-interrupt (IPI) priority. Smaller priority numbers win. A source controller offers interrupts one at a time. Each offer is answered with an accept or a refusal. When a better offer displaces a pending one, the displaced source is handed back to its owner.

The processor works the block through five register operations. Accept reads and acknowledges. Poll reads with no side effect. Two operations write the current priority and the IPI priority. End-of-interrupt (EOI) restores a priority and tells the source side which source finished. Whenever the presenter becomes idle and could take new work, it pulses a resend request so that the source side offers again. An IPI is produced inside the block from the IPI priority and always uses source number 2. The interrupt output is a level, and it is high exactly while a source is pending.

Top module: `irq_presenter`

## Requirements
- R1: After reset the presentation register reads 0, the pending priority is 0xFF (an accept straight after reset moves 0xFF into the top byte), the IPI priority reads 0xFF, and irq_o is low.
- R2: Bits 31:24 of the presentation register hold the current priority and bits 23:0 hold the pending source number. A source number of 0 means idle, and irq_o is high exactly when the source field is nonzero.
- R3: An offer with priority P is refused when P is not below the current priority, or when a source is pending whose pending priority is at most P. A refusal changes no state. Every offer is answered one cycle later on resp_valid_o, with resp_ok_o low for a refusal and resp_src_o echoing the offered source.
- R4: An offer that is not refused is latched with its priority and raises irq_o. If the pending source it displaces came from the source side, a drop pulse carries that old source number; a displaced IPI produces no drop.
- R5: Accept (op code 0) returns the whole old register on rd_data_o one cycle later. It then loads the old pending priority into bits 31:24, clears the source field, sets the pending priority to 0xFF and lowers irq_o.
- R6: Poll (op code 1) returns the register on rd_data_o and the IPI priority on rd_ipi_o and changes nothing. Op codes 5 to 7 have no effect at all.
- R7: Setting the current priority (op code 2, value in bits 7:0) to C below the old value drops a pending source whose pending priority is at least C. The pending priority returns to 0xFF, irq_o falls, and a drop pulse is sent if the source came from the source side.
- R8: Setting the current priority to a value equal to or above the old one while idle pulses resend_o. Before that, an IPI is latched if the IPI priority is below the new current priority.
- R9: Setting the IPI priority (op code 3, value in bits 7:0) to M below the current priority leaves state alone when a source is pending with pending priority at most M. Otherwise it drops any source-owned pending source and latches source 2 with pending priority M.
- R10: EOI (op code 4) loads bits 31:24 of the written value into the current priority and pulses eoi_valid_o with bits 23:0 on eoi_src_o. If the presenter is idle, it then runs the R8 resend with the IPI check.
- R11: An offer arriving in the same cycle as an operation is refused, and the operation proceeds as if alone.
- R12: Every pulse output is high for one cycle only, one cycle after its cause, and is low in cycles with no cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Offer from the source side |
| req_src_i | input | SRC_W | Offered source number |
| req_prio_i | input | 8 | Offered priority |
| op_valid_i | input | 1 | Register operation strobe |
| op_code_i | input | 3 | Operation: 0 accept, 1 poll, 2 current priority, 3 IPI priority, 4 EOI |
| op_data_i | input | 8+SRC_W | Operation write value |
| irq_o | output | 1 | Level interrupt to the processor |
| resp_valid_o | output | 1 | Answer to an offer |
| resp_ok_o | output | 1 | 1 accepted, 0 refused |
| resp_src_o | output | SRC_W | Source the answer refers to |
| drop_valid_o | output | 1 | A pending source is handed back |
| drop_src_o | output | SRC_W | Source handed back |
| eoi_valid_o | output | 1 | End-of-interrupt forwarded |
| eoi_src_o | output | SRC_W | Source that finished |
| resend_o | output | 1 | Request for the source side to offer again |
| rd_valid_o | output | 1 | Read data valid after accept or poll |
| rd_data_o | output | 8+SRC_W | Presentation register before the operation |
| rd_ipi_o | output | 8 | IPI priority |

## Verification
The bench walks grids of current priority, pending priority and offered priority. It hits the equal-priority edges, where an off-by-one compare would wrongly accept a tie or wrongly refuse a strictly better offer. It lowers the current priority to just above, equal to and below the pending priority. A design with the wrong inequality there would keep an interrupt that must go, or drop one that must stay. It also sets the IPI priority around a pending IPI and a pending source-owned interrupt. A design that did not track ownership would send a drop for the internal IPI. A design that skipped the IPI check inside EOI or resend would leave the processor idle with an IPI due.

// File: rtl/irq_pres_pkg.sv
package irq_pres_pkg;
  localparam int PRIO_W = 8;
  typedef logic [PRIO_W-1:0] prio_t;
  localparam prio_t PRIO_IDLE = '1;

  typedef enum logic [2:0] {
    OP_ACCEPT  = 3'd0,
    OP_POLL    = 3'd1,
    OP_SET_CUR = 3'd2,
    OP_SET_IPI = 3'd3,
    OP_EOI     = 3'd4
  } op_e;

  // an offer wins when strictly better than the current priority and than any pending one
  function automatic logic offer_wins(prio_t p, prio_t cur, logic busy, prio_t pend);
    return (p < cur) && !(busy && (pend <= p));
  endfunction

  // the IPI takes the slot unless the pending source is at least as favoured
  function automatic logic ipi_takes_slot(logic busy, prio_t pend, prio_t ipi);
    return !(busy && (pend <= ipi));
  endfunction

  // lowering the current priority evicts a pending source no better than it
  function automatic logic cur_evicts(prio_t c, prio_t old, logic busy, prio_t pend);
    return (c < old) && busy && (c <= pend);
  endfunction
endpackage

// File: rtl/irq_pres_admit.sv
module irq_pres_admit
  import irq_pres_pkg::*;
(
  input  logic  req_valid_i,
  input  logic  op_valid_i,
  input  prio_t req_prio_i,
  input  prio_t cur_i,
  input  prio_t pend_i,
  input  logic  busy_i,
  input  logic  own_i,
  output logic  admit_o,
  output logic  displace_o
);
  // an operation in the same cycle takes the state path; the offer is refused
  assign admit_o    = req_valid_i && !op_valid_i && offer_wins(req_prio_i, cur_i, busy_i, pend_i);
  assign displace_o = admit_o && busy_i && own_i;
endmodule

// File: rtl/irq_pres_opexec.sv
module irq_pres_opexec
  import irq_pres_pkg::*;
#(
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2,
  localparam int REG_W  = PRIO_W + SRC_W
) (
  input  logic             op_valid_i,
  input  logic [2:0]       op_code_i,
  input  logic [REG_W-1:0] op_data_i,
  input  prio_t            cur_i,
  input  logic [SRC_W-1:0] src_i,
  input  prio_t            pend_i,
  input  prio_t            ipi_i,
  input  logic             own_i,
  input  logic             irq_i,
  output prio_t            cur_o,
  output logic [SRC_W-1:0] src_o,
  output prio_t            pend_o,
  output prio_t            ipi_o,
  output logic             own_o,
  output logic             irq_o,
  output logic             drop_o,
  output logic             eoi_o,
  output logic             resend_o,
  output logic             rd_o
);
  localparam logic [SRC_W-1:0] IPI_NUM = SRC_W'(IPI_SRC);

  logic  busy;
  prio_t wr_lo;
  prio_t wr_hi;

  assign busy  = (src_i != '0);
  assign wr_lo = op_data_i[PRIO_W-1:0];
  assign wr_hi = op_data_i[REG_W-1 -: PRIO_W];

  always_comb begin
    cur_o    = cur_i;
    src_o    = src_i;
    pend_o   = pend_i;
    ipi_o    = ipi_i;
    own_o    = own_i;
    irq_o    = irq_i;
    drop_o   = 1'b0;
    eoi_o    = 1'b0;
    resend_o = 1'b0;
    rd_o     = 1'b0;
    if (op_valid_i) begin
      case (op_code_i)
        OP_ACCEPT: begin
          rd_o   = 1'b1;
          cur_o  = pend_i;
          src_o  = '0;
          pend_o = PRIO_IDLE;
          own_o  = 1'b0;
          irq_o  = 1'b0;
        end
        OP_POLL: rd_o = 1'b1;
        OP_SET_CUR: begin
          cur_o = wr_lo;
          if (wr_lo < cur_i) begin
            if (cur_evicts(wr_lo, cur_i, busy, pend_i)) begin
              drop_o = own_i;
              src_o  = '0;
              pend_o = PRIO_IDLE;
              own_o  = 1'b0;
              irq_o  = 1'b0;
            end
          end else if (!busy) begin
            resend_o = 1'b1;
            if (ipi_i < wr_lo) begin
              src_o  = IPI_NUM;
              pend_o = ipi_i;
              own_o  = 1'b0;
              irq_o  = 1'b1;
            end
          end
        end
        OP_SET_IPI: begin
          ipi_o = wr_lo;
          if ((wr_lo < cur_i) && ipi_takes_slot(busy, pend_i, wr_lo)) begin
            drop_o = busy && own_i;
            src_o  = IPI_NUM;
            pend_o = wr_lo;
            own_o  = 1'b0;
            irq_o  = 1'b1;
          end
        end
        OP_EOI: begin
          cur_o = wr_hi;
          eoi_o = 1'b1;
          if (!busy) begin
            resend_o = 1'b1;
            if (ipi_i < wr_hi) begin
              src_o  = IPI_NUM;
              pend_o = ipi_i;
              own_o  = 1'b0;
              irq_o  = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_pres_state.sv
module irq_pres_state
  import irq_pres_pkg::*;
#(
  parameter int SRC_W  = 24,
  localparam int REG_W = PRIO_W + SRC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  prio_t            cur_d,
  input  logic [SRC_W-1:0] src_d,
  input  prio_t            pend_d,
  input  prio_t            ipi_d,
  input  logic             own_d,
  input  logic             irq_d,
  input  logic             resp_d,
  input  logic             resp_ok_d,
  input  logic [SRC_W-1:0] resp_src_d,
  input  logic             drop_d,
  input  logic             eoi_d,
  input  logic [SRC_W-1:0] eoi_src_d,
  input  logic             resend_d,
  input  logic             rd_d,
  output prio_t            cur_q,
  output logic [SRC_W-1:0] src_q,
  output prio_t            pend_q,
  output prio_t            ipi_q,
  output logic             own_q,
  output logic             irq_q,
  output logic             resp_q,
  output logic             resp_ok_q,
  output logic [SRC_W-1:0] resp_src_q,
  output logic             drop_q,
  output logic [SRC_W-1:0] drop_src_q,
  output logic             eoi_q,
  output logic [SRC_W-1:0] eoi_src_q,
  output logic             resend_q,
  output logic             rd_q,
  output logic [REG_W-1:0] rd_data_q,
  output prio_t            rd_ipi_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q      <= '0;
      src_q      <= '0;
      pend_q     <= PRIO_IDLE;
      ipi_q      <= PRIO_IDLE;
      own_q      <= 1'b0;
      irq_q      <= 1'b0;
      resp_q     <= 1'b0;
      resp_ok_q  <= 1'b0;
      resp_src_q <= '0;
      drop_q     <= 1'b0;
      drop_src_q <= '0;
      eoi_q      <= 1'b0;
      eoi_src_q  <= '0;
      resend_q   <= 1'b0;
      rd_q       <= 1'b0;
      rd_data_q  <= '0;
      rd_ipi_q   <= PRIO_IDLE;
    end else begin
      cur_q      <= cur_d;
      src_q      <= src_d;
      pend_q     <= pend_d;
      ipi_q      <= ipi_d;
      own_q      <= own_d;
      irq_q      <= irq_d;
      resp_q     <= resp_d;
      resp_ok_q  <= resp_ok_d;
      resp_src_q <= resp_src_d;
      drop_q     <= drop_d;
      drop_src_q <= src_q;
      eoi_q      <= eoi_d;
      eoi_src_q  <= eoi_src_d;
      resend_q   <= resend_d;
      rd_q       <= rd_d;
      if (rd_d) begin
        rd_data_q <= {cur_q, src_q};
        rd_ipi_q  <= ipi_q;
      end
    end
  end

  // R2: the level output follows the source field
  p_irq_tracks_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (src_q != '0));
  // R5: an idle presenter always holds the idle pending priority
  p_idle_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == '0) |-> (pend_q == PRIO_IDLE));
  // R4: a drop hands back the source that was pending before the edge
  p_drop_old_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drop_q |-> (drop_src_q == $past(src_q)) && ($past(src_q) != '0));
  // R5: read data is the register as it stood before the operation
  p_rd_old_reg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q |-> (rd_data_q == {$past(cur_q), $past(src_q)}));
  // R4: an accepted offer is now the pending source
  p_ok_latched_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_q && resp_ok_q) |-> (src_q == resp_src_q) && irq_q && own_q);
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
  import irq_pres_pkg::*;
#(
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2,
  localparam int REG_W  = PRIO_W + SRC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid_i,
  input  logic [SRC_W-1:0] req_src_i,
  input  logic [7:0]       req_prio_i,
  input  logic             op_valid_i,
  input  logic [2:0]       op_code_i,
  input  logic [REG_W-1:0] op_data_i,
  output logic             irq_o,
  output logic             resp_valid_o,
  output logic             resp_ok_o,
  output logic [SRC_W-1:0] resp_src_o,
  output logic             drop_valid_o,
  output logic [SRC_W-1:0] drop_src_o,
  output logic             eoi_valid_o,
  output logic [SRC_W-1:0] eoi_src_o,
  output logic             resend_o,
  output logic             rd_valid_o,
  output logic [REG_W-1:0] rd_data_o,
  output logic [7:0]       rd_ipi_o
);
  prio_t            cur_q, pend_q, ipi_q;
  logic [SRC_W-1:0] src_q;
  logic             own_q, irq_q;

  // named internal events
  logic             admit_w, displace_w;
  prio_t            ox_cur, ox_pend, ox_ipi;
  logic [SRC_W-1:0] ox_src;
  logic             ox_own, ox_irq, ox_drop, ox_eoi, ox_resend, ox_rd;

  prio_t            n_cur, n_pend, n_ipi;
  logic [SRC_W-1:0] n_src;
  logic             n_own, n_irq, n_drop;

  irq_pres_admit u_admit (
    .req_valid_i (req_valid_i),
    .op_valid_i  (op_valid_i),
    .req_prio_i  (req_prio_i),
    .cur_i       (cur_q),
    .pend_i      (pend_q),
    .busy_i      (src_q != '0),
    .own_i       (own_q),
    .admit_o     (admit_w),
    .displace_o  (displace_w)
  );

  irq_pres_opexec #(.SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) u_opexec (
    .op_valid_i (op_valid_i),
    .op_code_i  (op_code_i),
    .op_data_i  (op_data_i),
    .cur_i      (cur_q),
    .src_i      (src_q),
    .pend_i     (pend_q),
    .ipi_i      (ipi_q),
    .own_i      (own_q),
    .irq_i      (irq_q),
    .cur_o      (ox_cur),
    .src_o      (ox_src),
    .pend_o     (ox_pend),
    .ipi_o      (ox_ipi),
    .own_o      (ox_own),
    .irq_o      (ox_irq),
    .drop_o     (ox_drop),
    .eoi_o      (ox_eoi),
    .resend_o   (ox_resend),
    .rd_o       (ox_rd)
  );

  always_comb begin
    if (admit_w) begin
      n_cur  = cur_q;
      n_src  = req_src_i;
      n_pend = req_prio_i;
      n_ipi  = ipi_q;
      n_own  = 1'b1;
      n_irq  = 1'b1;
      n_drop = displace_w;
    end else begin
      n_cur  = ox_cur;
      n_src  = ox_src;
      n_pend = ox_pend;
      n_ipi  = ox_ipi;
      n_own  = ox_own;
      n_irq  = ox_irq;
      n_drop = ox_drop;
    end
  end

  irq_pres_state #(.SRC_W(SRC_W)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur_d      (n_cur),
    .src_d      (n_src),
    .pend_d     (n_pend),
    .ipi_d      (n_ipi),
    .own_d      (n_own),
    .irq_d      (n_irq),
    .resp_d     (req_valid_i),
    .resp_ok_d  (admit_w),
    .resp_src_d (req_src_i),
    .drop_d     (n_drop),
    .eoi_d      (ox_eoi),
    .eoi_src_d  (op_data_i[SRC_W-1:0]),
    .resend_d   (ox_resend),
    .rd_d       (ox_rd),
    .cur_q      (cur_q),
    .src_q      (src_q),
    .pend_q     (pend_q),
    .ipi_q      (ipi_q),
    .own_q      (own_q),
    .irq_q      (irq_q),
    .resp_q     (resp_valid_o),
    .resp_ok_q  (resp_ok_o),
    .resp_src_q (resp_src_o),
    .drop_q     (drop_valid_o),
    .drop_src_q (drop_src_o),
    .eoi_q      (eoi_valid_o),
    .eoi_src_q  (eoi_src_o),
    .resend_q   (resend_o),
    .rd_q       (rd_valid_o),
    .rd_data_q  (rd_data_o),
    .rd_ipi_q   (rd_ipi_o)
  );

  assign irq_o = irq_q;

  // R3: every offer is answered in the next cycle
  p_resp_follows_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid_i) |-> resp_valid_o);
  // R11: an offer colliding with an operation is refused
  p_collision_nak_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid_i && op_valid_i) |-> resp_valid_o && !resp_ok_o);
  // R10: EOI forwards the low field of the written value
  p_eoi_forward_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_valid_i && (op_code_i == OP_EOI)) |->
      eoi_valid_o && (eoi_src_o == $past(op_data_i[SRC_W-1:0])));
  // R5: accept leaves the output low and produces read data
  p_accept_lowers_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_valid_i && (op_code_i == OP_ACCEPT)) |-> !irq_o && rd_valid_o);
endmodule

// File: tb/irq_presenter_tb_top.sv
`timescale 1ns/1ps
module irq_presenter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [23:0] req_src = '0;
  logic [7:0]  req_prio = '0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [31:0] op_data = '0;
  logic        irq, resp_valid, resp_ok, drop_valid, eoi_valid, resend, rd_valid;
  logic [23:0] resp_src, drop_src, eoi_src;
  logic [31:0] rd_data;
  logic [7:0]  rd_ipi;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench-side view of the presenter, rebuilt from the requirements
  logic [7:0]  m_cur, m_pend, m_ipi;
  logic [23:0] m_src;
  bit          m_own;
  bit          e_drop, e_res;

  always #10 clk = ~clk;

  irq_presenter dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_src_i(req_src), .req_prio_i(req_prio),
    .op_valid_i(op_valid), .op_code_i(op_code), .op_data_i(op_data),
    .irq_o(irq), .resp_valid_o(resp_valid), .resp_ok_o(resp_ok), .resp_src_o(resp_src),
    .drop_valid_o(drop_valid), .drop_src_o(drop_src),
    .eoi_valid_o(eoi_valid), .eoi_src_o(eoi_src), .resend_o(resend),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_ipi_o(rd_ipi)
  );

  task automatic chk(string tg, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tg, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic m_ipi_check();
    if (m_src != 0 && m_pend <= m_ipi) return;
    e_drop = e_drop || (m_src != 0 && m_own);
    m_src = 24'd2; m_pend = m_ipi; m_own = 0;
  endtask

  task automatic m_resend();
    if (m_ipi < m_cur) m_ipi_check();
    e_res = 1;
  endtask

  task automatic cyc(bit rv, logic [23:0] rs, logic [7:0] rp,
                     bit ov, logic [2:0] oc, logic [31:0] od, string tg);
    bit          busy = (m_src != 0);
    bit          e_ok = 0, e_eoi = 0, e_rd = 0;
    logic [23:0] e_dsrc = m_src;
    logic [31:0] e_rdd = {m_cur, m_src};
    logic [7:0]  e_rdi = m_ipi;
    e_drop = 0; e_res = 0;
    if (ov) begin
      case (oc)
        3'd0: begin e_rd = 1; m_cur = m_pend; m_src = 0; m_pend = 8'hFF; m_own = 0; end
        3'd1: e_rd = 1;
        3'd2: begin
          if (od[7:0] < m_cur) begin
            m_cur = od[7:0];
            if (busy && m_pend >= od[7:0]) begin
              e_drop = m_own; m_src = 0; m_pend = 8'hFF; m_own = 0;
            end
          end else begin
            m_cur = od[7:0];
            if (!busy) m_resend();
          end
        end
        3'd3: begin m_ipi = od[7:0]; if (m_ipi < m_cur) m_ipi_check(); end
        3'd4: begin m_cur = od[31:24]; e_eoi = 1; if (!busy) m_resend(); end
        default: ;
      endcase
    end else if (rv) begin
      if (!(rp >= m_cur || (busy && m_pend <= rp))) begin
        e_ok = 1; e_drop = busy && m_own;
        m_src = rs; m_pend = rp; m_own = 1;
      end
    end
    req_valid = rv; req_src = rs; req_prio = rp;
    op_valid = ov; op_code = oc; op_data = od;
    @(posedge clk); #1;
    chk(tg, "resp_valid", resp_valid, rv);
    if (rv) begin
      chk(tg, "resp_ok", resp_ok, e_ok);
      chk(tg, "resp_src", resp_src, rs);
    end
    chk(tg, "drop_valid", drop_valid, e_drop);
    if (e_drop) chk(tg, "drop_src", drop_src, e_dsrc);
    chk(tg, "eoi_valid", eoi_valid, e_eoi);
    if (e_eoi) chk(tg, "eoi_src", eoi_src, od[23:0]);
    chk(tg, "resend", resend, e_res);
    chk(tg, "rd_valid", rd_valid, e_rd);
    if (e_rd) begin
      chk(tg, "rd_data", rd_data, e_rdd);
      chk(tg, "rd_ipi", rd_ipi, e_rdi);
    end
    chk(tg, "irq", irq, m_src != 0);
    @(negedge clk);
    req_valid = 0; op_valid = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_cur = 0; m_src = 0; m_pend = 8'hFF; m_ipi = 8'hFF; m_own = 0;
  endtask

  task automatic offer(logic [23:0] s, logic [7:0] p, string tg);
    cyc(1, s, p, 0, 3'd0, 32'd0, tg);
  endtask

  task automatic op(logic [2:0] c, logic [31:0] d, string tg);
    cyc(0, 24'd0, 8'd0, 1, c, d, tg);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] cur_set[3] = '{8'h10, 8'h80, 8'hFF};
    logic [7:0] pre_set[4] = '{8'h00, 8'h08, 8'h40, 8'h90};
    logic [7:0] new_set[6] = '{8'h00, 8'h08, 8'h40, 8'h7F, 8'h80, 8'hFE};
    logic [7:0] ipi_set[6] = '{8'h00, 8'h10, 8'h20, 8'h40, 8'h80, 8'hFF};
    logic [7:0] low_set[6] = '{8'h00, 8'h20, 8'h30, 8'h60, 8'h90, 8'hFF};
    @(negedge clk);
    do_reset();
    // R1: reset state, seen through poll and accept
    chk("R1", "irq", irq, 0);
    op(3'd1, 32'd0, "R1");
    op(3'd0, 32'd0, "R1");
    op(3'd1, 32'd0, "R1");
    cyc(0, 0, 0, 0, 0, 0, "R12");

    // R3 R4 R5: offer sweep over current, pending and offered priority
    foreach (cur_set[i]) foreach (pre_set[j]) foreach (new_set[k]) begin
      do_reset();
      op(3'd4, {cur_set[i], 24'd0}, "R10");
      if (pre_set[j] != 0) offer(24'h000100 + 24'(j), pre_set[j], "R4");
      offer(24'hABCDE, new_set[k], "R3");
      op(3'd1, 32'd0, "R2");
      op(3'd0, 32'd0, "R5");
      cyc(0, 0, 0, 0, 0, 0, "R12");
    end

    // R9 R10: IPI priority sweep around pending sources
    foreach (cur_set[i]) foreach (pre_set[j]) foreach (ipi_set[k]) begin
      do_reset();
      op(3'd4, {cur_set[i], 24'd0}, "R10");
      if (pre_set[j] != 0) offer(24'h000200, pre_set[j] + 8'h08, "R4");
      op(3'd3, {24'd0, ipi_set[k]}, "R9");
      op(3'd1, 32'd0, "R6");
      op(3'd0, 32'd0, "R5");
      op(3'd4, {8'hFF, 24'h000200}, "R10");
      op(3'd0, 32'd0, "R5");
    end

    // R7 R8: current priority written below, at and above the pending one
    for (int w = 0; w < 2; w++) foreach (pre_set[j]) foreach (low_set[k]) begin
      do_reset();
      op(3'd2, 32'h000000FF, "R8");
      if (w == 1) op(3'd3, 32'h00000050, "R9");
      if (pre_set[j] != 0) offer(24'h000300, pre_set[j] + 8'h20, "R4");
      op(3'd2, {24'd0, low_set[k]}, "R7");
      op(3'd1, 32'd0, "R6");
      op(3'd2, 32'h000000FF, "R8");
      op(3'd0, 32'd0, "R5");
    end

    // R11: offer colliding with every operation
    for (int c = 0; c < 5; c++) begin
      do_reset();
      op(3'd4, {8'hFF, 24'd0}, "R10");
      offer(24'h000400, 8'h40, "R4");
      cyc(1, 24'h000500, 8'h00, 1, 3'(c), {8'hC0, 24'h000400}, "R11");
      op(3'd1, 32'd0, "R11");
    end

    // R6: unused op codes leave everything alone
    do_reset();
    op(3'd4, {8'hFF, 24'd0}, "R10");
    offer(24'h000600, 8'h30, "R4");
    for (int c = 5; c < 8; c++) op(3'(c), 32'h00000000, "R6");
    op(3'd1, 32'd0, "R6");

    // R12: quiet cycles carry no pulses
    repeat (3) cyc(0, 0, 0, 0, 0, 0, "R12");
    summary();
  end
endmodule